// File: doc/BRIEF.md
# Clock Generator Configuration Serial Slave

This block is the two-wire serial slave for a clock generator's configuration space. It answers a fixed 7-bit device address and holds eight 8-bit control bytes. Seven bytes hold settings: output enables, stop and power-down drive modes, frequency and spread options. Those bytes leave the block as one parallel bus that the output and stop logic decode. The last byte is a fixed identification value.

A host reaches the space in two ways, chosen by the top bit of the command byte. It can reach one indexed byte, or it can run a counted sequential block transfer that always starts at byte 0. Part of byte 0 is live status rather than storage: the stop pin levels and the frequency-select straps captured after reset. SDA is driven only low, through an open-drain enable. SCL and SDA are sampled by the block's own clock, and the block never stretches SCL.

Top module: `clkcfg_smbus_slave`

## Requirements
- R1: After reset, `cfg_o` (byte k at bits 8k+7:8k) is byte0=0x40, byte1=0x7F, byte2=0x00, byte3=0xFF, byte4=0x47, byte5=0xDF, byte6=0x03; bits 3:0 of byte0 always read 0 on `cfg_o`.
- R2: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged. Any other address byte is not acknowledged, and the slave then acknowledges nothing and changes nothing until the next start condition.
- R3: Byte write: a command byte with bit 7 = 1 selects the offset in bits 6:0. The next data byte is written there and appears on `cfg_o`.
- R4: Byte read: a command with bit 7 = 1, a repeated start and 0xD3 make the slave return the byte at that offset, MSB first.
- R5: Block write: command 0x00, then a count byte, then data bytes stored at offsets 0, 1, 2 and upward. The count is acknowledged but sets no limit, and a stop after any complete byte leaves the later registers untouched.
- R6: Block read: command 0x00, a repeated start and 0xD3 make the slave return the count 0x08 first, then bytes 0 through 7 in order.
- R7: Byte 0 reads back bit2 = live level of `cpu_stop_ni`, bit1 = `fs_b_i` and bit0 = `fs_a_i`, both captured on the first clock after reset. Writes to bits 3:0 are ignored, and bits 7:4 are writable.
- R8: Byte 0 bit 3 reads `pci_stop_ni` AND byte3 bit 7.
- R9: Byte 7 always reads 0x48, and writes to it are acknowledged and ignored.
- R10: Writes to offsets 8 and above are acknowledged and discarded. Reads from those offsets return 0x00.
- R11: `sda_oe_o` = 1 pulls SDA low. It is 0 whenever the slave is idle or has been deselected, and it changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock that samples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| cpu_stop_ni | input | 1 | CPU clock stop pin, active low |
| pci_stop_ni | input | 1 | PCI clock stop pin, active low |
| fs_a_i | input | 1 | Frequency strap A |
| fs_b_i | input | 1 | Frequency strap B |
| cfg_o | output | 56 | Control bytes 0..6, byte k at bits 8k+7:8k |

## Verification
The hardest state to reach is the read path after a repeated start. The command byte must have been written earlier in the same transfer, and in a block read the pointer must not advance while the count byte goes out. The bench models a wired-AND bus and drives full transfers bit by bit. Each byte read follows a command write and a restart; a block read is acknowledged for nine bytes and refused on the last. Changing the stop and strap pins after reset shows which status bits are live and which were captured.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam logic [7:0] ID_VALUE    = 8'h48;
  localparam int unsigned SWSTOP_REG = 3;
  localparam int unsigned SWSTOP_BIT = 7;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK, S_WAIT} st_e;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_CNT, K_DATA} kind_e;

  function automatic logic [7:0] reg_default(int unsigned idx);
    case (idx)
      0:       return 8'h40;
      1:       return 8'h7F;
      2:       return 8'h00;
      3:       return 8'hFF;
      4:       return 8'h47;
      5:       return 8'hDF;
      6:       return 8'h03;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/clkcfg_bus_sync.sv
module clkcfg_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edges while SCL held high mark bus conditions
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
  import clkcfg_pkg::*;
#(
  parameter int unsigned NREG = 8,
  parameter int unsigned AW   = 7,
  localparam int unsigned NSTORE = NREG - 1,
  localparam int unsigned CW     = NSTORE * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          cpu_stop_ni,
  input  logic          pci_stop_ni,
  input  logic          fs_a_i,
  input  logic          fs_b_i,
  output logic [7:0]    rdata_o,
  output logic [CW-1:0] cfg_o
);
  logic [7:0] store_q [NSTORE];
  logic       cap_q;
  logic [1:0] fs_q;

  for (genvar g = 0; g < NSTORE; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) store_q[g] <= reg_default(g);
      else if (we_i && addr_i == AW'(g)) begin
        if (g == 0) store_q[g] <= {wdata_i[7:4], 4'h0};
        else        store_q[g] <= wdata_i;
      end
    end
    assign cfg_o[8*g +: 8] = store_q[g];
  end

  // straps captured once on the first clock after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= 1'b0;
      fs_q  <= 2'b00;
    end else if (!cap_q) begin
      cap_q <= 1'b1;
      fs_q  <= {fs_b_i, fs_a_i};
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == '0)
      rdata_o = {store_q[0][7:4], pci_stop_ni & store_q[SWSTOP_REG][SWSTOP_BIT],
                 cpu_stop_ni, fs_q};
    else if (addr_i == AW'(NREG-1))
      rdata_o = ID_VALUE;
    else
      for (int k = 1; k < NSTORE; k++)
        if (addr_i == AW'(k)) rdata_o = store_q[k];
  end

  // R3 R5: storage moves only on a write strobe
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_o));
endmodule

// File: rtl/clkcfg_proto.sv
module clkcfg_proto
  import clkcfg_pkg::*;
#(
  parameter logic [6:0]  SLV_ADDR = 7'h69,
  parameter int unsigned NREG     = 8,
  parameter int unsigned AW       = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [7:0]    rdata_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    wdata_o,
  output logic          sda_oe_o
);
  localparam logic [7:0] CNT_BYTE = 8'(NREG);

  st_e          st_q;
  kind_e        kind_q;
  logic [7:0]   sh_q;
  logic [3:0]   bitcnt_q;
  logic [AW-1:0] ptr_q;
  logic         rd_q, blk_q, first_q, sda_oe_q;
  logic         send_cnt;
  logic [7:0]   tx_sel;

  assign send_cnt = blk_q & first_q;
  assign tx_sel   = send_cnt ? CNT_BYTE : rdata_i;
  assign we_o     = (st_q == S_RX) && (kind_q == K_DATA) && scl_fall_i &&
                    (bitcnt_q == 4'd8) && !start_i && !stop_i;
  assign addr_o   = ptr_q;
  assign wdata_o  = sh_q;
  assign sda_oe_o = sda_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      kind_q   <= K_ADDR;
      sh_q     <= '0;
      bitcnt_q <= '0;
      ptr_q    <= '0;
      rd_q     <= 1'b0;
      blk_q    <= 1'b0;
      first_q  <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (start_i) begin
      st_q     <= S_RX;
      kind_q   <= K_ADDR;
      bitcnt_q <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_i) begin
      st_q     <= S_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_RX: begin
          if (scl_rise_i && bitcnt_q < 4'd8) begin
            sh_q     <= {sh_q[6:0], sda_i};
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (scl_fall_i && bitcnt_q == 4'd8) begin
            bitcnt_q <= '0;
            unique case (kind_q)
              K_ADDR: begin
                if (sh_q[7:1] == SLV_ADDR) begin
                  sda_oe_q <= 1'b1;
                  st_q     <= S_RACK;
                  rd_q     <= sh_q[0];
                  first_q  <= 1'b1;
                  kind_q   <= K_CMD;
                end else begin
                  st_q <= S_WAIT;
                end
              end
              K_CMD: begin
                blk_q    <= ~sh_q[7];
                ptr_q    <= sh_q[7] ? sh_q[AW-1:0] : '0;
                kind_q   <= sh_q[7] ? K_DATA : K_CNT;
                sda_oe_q <= 1'b1;
                st_q     <= S_RACK;
              end
              K_CNT: begin
                kind_q   <= K_DATA;
                sda_oe_q <= 1'b1;
                st_q     <= S_RACK;
              end
              default: begin
                ptr_q    <= ptr_q + 1'b1;
                sda_oe_q <= 1'b1;
                st_q     <= S_RACK;
              end
            endcase
          end
        end
        S_RACK, S_TACK: begin
          if (st_q == S_TACK && scl_rise_i && sda_i) begin
            st_q <= S_WAIT;                 // master refused, stop sending
          end else if (scl_fall_i) begin
            if (st_q == S_TACK || rd_q) begin
              sh_q     <= {tx_sel[6:0], 1'b0};
              sda_oe_q <= ~tx_sel[7];
              bitcnt_q <= 4'd1;
              first_q  <= 1'b0;
              st_q     <= S_TX;
              if (!send_cnt) ptr_q <= ptr_q + 1'b1;
            end else begin
              sda_oe_q <= 1'b0;
              st_q     <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall_i) begin
            if (bitcnt_q == 4'd8) begin
              sda_oe_q <= 1'b0;
              st_q     <= S_TACK;
            end else begin
              sda_oe_q <= ~sh_q[7];
              sh_q     <= {sh_q[6:0], 1'b0};
              bitcnt_q <= bitcnt_q + 4'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R11
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE || st_q == S_WAIT) |-> !sda_oe_q);
  // R11
  oe_scl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_q));
  // R2
  addr_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RX && kind_q == K_ADDR && scl_fall_i && bitcnt_q == 4'd8 &&
     sh_q[7:1] != SLV_ADDR && !start_i && !stop_i) |=> (st_q == S_WAIT && !sda_oe_q));
  // R4 R6
  bitcnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bitcnt_q <= 4'd8);
endmodule

// File: rtl/clkcfg_smbus_slave.sv
module clkcfg_smbus_slave #(
  parameter logic [6:0]  SLV_ADDR    = 7'h69,
  parameter int unsigned NREG        = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW = 7,
  localparam int unsigned CW = (NREG - 1) * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          cpu_stop_ni,
  input  logic          pci_stop_ni,
  input  logic          fs_a_i,
  input  logic          fs_b_i,
  output logic [CW-1:0] cfg_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic we;
  logic [AW-1:0] addr;
  logic [7:0] wdata, rdata;

  clkcfg_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  clkcfg_proto #(.SLV_ADDR(SLV_ADDR), .NREG(NREG), .AW(AW)) u_proto (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c), .rdata_i(rdata),
    .we_o(we), .addr_o(addr), .wdata_o(wdata), .sda_oe_o
  );

  clkcfg_regfile #(.NREG(NREG), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .cpu_stop_ni, .pci_stop_ni, .fs_a_i, .fs_b_i,
    .rdata_o(rdata), .cfg_o
  );
endmodule

// File: tb/clkcfg_smbus_slave_bench.sv
`timescale 1ns/1ps
module clkcfg_smbus_slave_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic cpu_n = 1'b1, pci_n = 1'b1, fs_a = 1'b1, fs_b = 1'b0;
  logic sda_oe;
  logic [55:0] cfg;
  wire sda_line = sda_m & ~sda_oe;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  clkcfg_smbus_slave u_clkcfg_smbus_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .cpu_stop_ni(cpu_n), .pci_stop_ni(pci_n),
    .fs_a_i(fs_a), .fs_b_i(fs_b), .cfg_o(cfg)
  );

  typedef struct packed { logic [7:0] off, wd, ex; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'h00, 8'hFF, 8'hFD}, '{8'h01, 8'hA5, 8'hA5}, '{8'h02, 8'h3C, 8'h3C},
    '{8'h06, 8'hFF, 8'hFF}, '{8'h07, 8'h00, 8'h48}, '{8'h09, 8'h77, 8'h00}};

  task automatic chk(string req, logic [71:0] act, logic [71:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hw(); repeat (10) @(negedge clk); endtask

  task automatic bstart();
    sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
  endtask

  task automatic bstop();
    sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0;
    end
    sda_m = 1'b1; hw(); scl_m = 1'b1; hw();
    ack = ~sda_line;
    scl_m = 1'b0; hw();
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hw(); scl_m = 1'b1; hw(); b = {b[6:0], sda_line}; scl_m = 1'b0;
    end
    sda_m = ~mack; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0; hw(); sda_m = 1'b1;
  endtask

  task automatic write_reg(input logic [7:0] off, input logic [7:0] d, output logic [2:0] acks);
    bstart();
    wbyte(8'hD2, acks[2]); wbyte({1'b1, off[6:0]}, acks[1]); wbyte(d, acks[0]);
    bstop();
  endtask

  task automatic read_reg(input logic [7:0] off, output logic [7:0] d);
    logic a;
    bstart(); wbyte(8'hD2, a); wbyte({1'b1, off[6:0]}, a);
    bstart(); wbyte(8'hD3, a); rbyte(1'b0, d);
    bstop();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] d, cnt;
    logic [63:0] blk;
    logic a;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset values
    chk("R1 reset cfg", 72'(cfg), 72'({8'h03, 8'hDF, 8'h47, 8'hFF, 8'h00, 8'h7F, 8'h40}));
    chk("R11 idle release", 72'(sda_oe), 72'(0));
    // straps move after capture; R7 expects captured A=1 B=0
    fs_a = 1'b0; fs_b = 1'b1;

    // R3 R4 R7 R9 R10 table walk
    for (int i = 0; i < 6; i++) begin
      write_reg(VECS[i].off, VECS[i].wd, acks);
      chk("R2 R10 write acks", 72'(acks), 72'(3'b111));
      read_reg(VECS[i].off, d);
      chk(VECS[i].off == 0 ? "R7 byte0 read" : VECS[i].off == 7 ? "R9 id read" :
          VECS[i].off >= 8 ? "R10 high offset read" : "R4 byte read", 72'(d), 72'(VECS[i].ex));
    end
    chk("R3 cfg after byte writes", 72'(cfg),
        72'({8'hFF, 8'hDF, 8'h47, 8'hFF, 8'h3C, 8'hA5, 8'hF0}));

    // R2 foreign address
    bstart(); wbyte(8'hA4, a); chk("R2 foreign addr nack", 72'(a), 72'(0));
    wbyte(8'h81, a); chk("R2 deselected cmd nack", 72'(a), 72'(0));
    wbyte(8'h55, a); chk("R2 deselected data nack", 72'(a), 72'(0));
    bstop();
    chk("R2 cfg untouched", 72'(cfg[15:8]), 72'(8'hA5));

    // R5 block write, stop after three data bytes
    bstart(); wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'h03, a);
    chk("R5 count ack", 72'(a), 72'(1));
    wbyte(8'h11, a); wbyte(8'h22, a); wbyte(8'h33, a); bstop();
    chk("R5 block write cfg", 72'(cfg[31:0]), 72'(32'hFF332210));

    // R6 block read
    bstart(); wbyte(8'hD2, a); wbyte(8'h00, a);
    bstart(); wbyte(8'hD3, a);
    rbyte(1'b1, cnt);
    for (int i = 0; i < 8; i++) begin
      rbyte(i != 7, d);
      blk = {blk[55:0], d};
    end
    bstop();
    chk("R6 block read count", 72'(cnt), 72'(8'h08));
    chk("R6 block read data", 72'(blk), 72'(64'h1D2233FF47DFFF48));
    chk("R11 released after nack", 72'(sda_oe), 72'(0));

    // R8 composite stop bit
    pci_n = 1'b0; read_reg(8'h00, d); chk("R8 pin low", 72'(d), 72'(8'h15));
    pci_n = 1'b1; write_reg(8'h03, 8'h7F, acks);
    read_reg(8'h00, d); chk("R8 soft bit low", 72'(d), 72'(8'h15));
    write_reg(8'h03, 8'hFF, acks);
    read_reg(8'h00, d); chk("R8 both high", 72'(d), 72'(8'h1D));
    // R7 live cpu stop bit
    cpu_n = 1'b0; read_reg(8'h00, d); chk("R7 cpu stop live", 72'(d), 72'(8'h19));
    cpu_n = 1'b1;
    // R10 far offset
    read_reg(8'h20, d); chk("R10 offset 0x20", 72'(d), 72'(8'h00));
    chk("R11 idle at end", 72'(sda_oe), 72'(0));

    summary();
    $finish;
  end
endmodule